// File: doc/BRIEF.md
# Delayed Read Retry Controller

This block runs the target-side half of a delayed read inside a bus bridge. Once the bridge has taken a read from an initiator and told it to come back later, the controller accepts the read through a valid/ready handshake and latches whether the read is prefetchable and how many data words the initiator wants. It then pulses an issue strobe for each attempt on the target bus. It re-issues the read every time the target answers with retry. It stops when the read ends with data, with an abort, or when the retry budget is used up.

When an attempt ends, the controller turns the target-side termination into the code that the bridge returns to the initiator. It sets two sticky abort flags when the target aborts. It raises a one-cycle system-error pulse when the budget runs out, but only if error reporting is enabled and the non-delivery report is not disabled. Software clears the flags with a write-one-to-clear strobe.

Top module: `dly_rd_retry_ctrl`

## Requirements
- R1: After reset `req_ready` is 1 and `tgt_issue`, `rsp_valid`, `serr_pulse` and both flags are 0. A request taken while `req_ready` is 1 drives `tgt_issue` high for exactly the next cycle.
- R2: An attempt that ends with termination code 1 (retry) while the budget is not spent brings `tgt_issue` high in the next cycle and raises no response.
- R3: The RETRY_LIMIT-th consecutive retry ends the read with response code 4 (retry limit) and no further issue. The retry count restarts from zero for every newly accepted request.
- R4: On that exhaustion `serr_pulse` is high for one cycle only when `cfg_serr_en` is 1 and `cfg_nodeliv_dis` is 0. Otherwise it stays 0.
- R5: Termination code 3 (target abort) gives response code 2 and sets flag bit 0 (target side received abort) and flag bit 1 (initiator side signaled abort).
- R6: Termination code 4 (master abort) gives response code 3, with no retry and no change to the flags.
- R7: Termination code 0 (normal) on a prefetchable read gives code 1 (disconnect) when the requested length exceeds `tgt_xfer_cnt`, and code 0 (complete) otherwise.
- R8: Termination code 0 on a non-prefetchable read always gives code 1 (disconnect).
- R9: Termination code 2 (disconnect) gives code 1 when the requested length exceeds `tgt_xfer_cnt`, and code 0 otherwise, whatever the prefetch flag.
- R10: Writing with `sts_wr_en` clears each flag whose `sts_wr_data` bit is 1 and leaves flags with a 0 bit unchanged. A set in the same cycle wins over the clear.
- R11: While a read is in progress `req_ready` is 0 and a request on `req_valid` is ignored: its length and prefetch flag do not affect the read under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Delayed read offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_prefetch | input | 1 | Read targets prefetchable space |
| req_len | input | LEN_W | Data words the initiator asks for |
| tgt_issue | output | 1 | Start one attempt on the target bus |
| tgt_done | input | 1 | Current attempt has ended |
| tgt_term | input | 3 | Termination: 0 normal, 1 retry, 2 disconnect, 3 target abort, 4 master abort |
| tgt_xfer_cnt | input | LEN_W | Data words read in the attempt |
| cfg_serr_en | input | 1 | System error reporting enabled |
| cfg_nodeliv_dis | input | 1 | Suppress the non-delivery error |
| rsp_valid | output | 1 | One-cycle strobe, initiator response ready |
| rsp_code | output | 3 | 0 complete, 1 disconnect, 2 target abort, 3 master abort, 4 retry limit |
| sts_wr_en | input | 1 | Flag write strobe |
| sts_wr_data | input | 2 | Write-one-to-clear mask for the flags |
| sts_rcv_tabort | output | 1 | Flag bit 0: target side received target abort |
| sts_sig_tabort | output | 1 | Flag bit 1: initiator side signaled target abort |
| serr_pulse | output | 1 | One-cycle system error |

## Verification
The bench builds the controller with RETRY_LIMIT set to 4 and an 8-bit length. With a budget this small, the saturating counter, the exhaustion response and the gated error pulse can all be reached in a few dozen cycles. The bench also shows that a second request gets a fresh budget. The 8-bit length still separates the cases where the requested length is below, equal to or above the fetched count. The default budget of 2^24 keeps the same counter logic, only wider.

// File: rtl/dlyrd_pkg.sv
// Shared encodings for the delayed read retry controller.
// Assumes termination codes above 4 are never presented by the bus side.
package dlyrd_pkg;

    typedef enum logic [2:0] {
        TERM_NORMAL = 3'd0,
        TERM_RETRY  = 3'd1,
        TERM_DISC   = 3'd2,
        TERM_TABORT = 3'd3,
        TERM_MABORT = 3'd4
    } tgt_term_e;

    typedef enum logic [2:0] {
        RSP_COMPLETE = 3'd0,
        RSP_DISC     = 3'd1,
        RSP_TABORT   = 3'd2,
        RSP_MABORT   = 3'd3,
        RSP_GIVEUP   = 3'd4
    } ini_rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/dlyrd_term_map.sv
// Maps the termination of a finished target attempt to the initiator response.
// Purely combinational. It assumes the request fields are already latched and
// that the transfer count is valid whenever a termination is presented.
module dlyrd_term_map
    import dlyrd_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic [2:0]       term,
    input  logic             prefetch,
    input  logic [LEN_W-1:0] want_len,
    input  logic [LEN_W-1:0] got_len,
    output ini_rsp_e         code
);

    logic short_read;

    // Initiator asked for more words than the target delivered.
    assign short_read = (want_len > got_len);

    // Choose the initiator response for each termination kind.
    always_comb begin
        unique case (tgt_term_e'(term))
            TERM_NORMAL: begin
                if (!prefetch)       code = RSP_DISC;
                else if (short_read) code = RSP_DISC;
                else                 code = RSP_COMPLETE;
            end
            TERM_DISC:   code = short_read ? RSP_DISC : RSP_COMPLETE;
            TERM_TABORT: code = RSP_TABORT;
            TERM_MABORT: code = RSP_MABORT;
            default:     code = RSP_MABORT;
        endcase
    end

endmodule

// File: rtl/dlyrd_seq.sv
// Attempt sequencer: accepts one delayed read, issues it on the target bus,
// re-issues on retry and counts retries against a saturating budget.
// Assumes tgt_done is only meaningful in the cycle after an issue or later.
module dlyrd_seq
    import dlyrd_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int RETRY_LIMIT = 1 << 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_prefetch,
    input  logic [LEN_W-1:0] req_len,
    output logic             tgt_issue,
    input  logic             tgt_done,
    input  logic [2:0]       tgt_term,
    output logic             pf_q,
    output logic [LEN_W-1:0] len_q,
    input  ini_rsp_e         map_code,
    output logic             rsp_valid,
    output ini_rsp_e         rsp_code,
    output logic             fin_tabort,
    output logic             exhaust
);

    localparam int CNT_W = $clog2(RETRY_LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RETRY_LIMIT - 1);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(RETRY_LIMIT);

    seq_state_e       state;
    logic [CNT_W-1:0] retry_cnt;
    logic             ended;
    logic             is_retry;
    logic             last_try;

    // Handshake and issue strobe decode from the state.
    assign req_ready = (state == ST_IDLE);
    assign tgt_issue = (state == ST_ISSUE);

    // Attempt end and its classification.
    assign ended      = (state == ST_WAIT) && tgt_done;
    assign is_retry   = (tgt_term_e'(tgt_term) == TERM_RETRY);
    assign last_try   = (retry_cnt >= CNT_LAST);
    assign exhaust    = ended && is_retry && last_try;
    assign fin_tabort = ended && (tgt_term_e'(tgt_term) == TERM_TABORT);

    // State, retry budget, latched request and registered response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            retry_cnt <= '0;
            pf_q      <= 1'b0;
            len_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_code  <= RSP_COMPLETE;
        end else begin
            rsp_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state     <= ST_ISSUE;
                        retry_cnt <= '0;
                        pf_q      <= req_prefetch;
                        len_q     <= req_len;
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (tgt_done) begin
                        if (is_retry && last_try) begin
                            state     <= ST_IDLE;
                            retry_cnt <= CNT_SAT;
                            rsp_valid <= 1'b1;
                            rsp_code  <= RSP_GIVEUP;
                        end else if (is_retry) begin
                            state     <= ST_ISSUE;
                            retry_cnt <= retry_cnt + 1'b1;
                        end else begin
                            state     <= ST_IDLE;
                            rsp_valid <= 1'b1;
                            rsp_code  <= map_code;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // An accepted request leads to an issue in the next cycle.
    assert_accept_issues_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> tgt_issue);

    // An issue strobe lasts exactly one cycle.
    assert_issue_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_issue |=> !tgt_issue);

    // A retry inside the budget re-issues and raises no response.
    assert_retry_reissue_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ended && is_retry && !last_try) |=> (tgt_issue && !rsp_valid));

    // The retry-limit response only follows a retry termination.
    assert_giveup_after_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == RSP_GIVEUP) |-> $past(tgt_done && is_retry));

    // The retry count never passes the budget.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        retry_cnt <= CNT_SAT);

    // No request is taken while an attempt is pending.
    assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_issue |-> !req_ready);

endmodule

// File: rtl/dlyrd_status.sv
// Sticky abort flags with write-one-to-clear, and the gated system-error pulse.
// Assumes set and clear may coincide; the set takes priority.
module dlyrd_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_tabort,
    input  logic       exhaust,
    input  logic       cfg_serr_en,
    input  logic       cfg_nodeliv_dis,
    input  logic       wr_en,
    input  logic [1:0] wr_data,
    output logic       rcv_tabort,
    output logic       sig_tabort,
    output logic       serr_pulse
);

    logic clr_rcv;
    logic clr_sig;

    // Per-flag clear requests from the write port.
    assign clr_rcv = wr_en && wr_data[0];
    assign clr_sig = wr_en && wr_data[1];

    // Sticky flags: set wins over clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcv_tabort <= 1'b0;
            sig_tabort <= 1'b0;
        end else begin
            rcv_tabort <= set_tabort || (rcv_tabort && !clr_rcv);
            sig_tabort <= set_tabort || (sig_tabort && !clr_sig);
        end
    end

    // One-cycle system error on an exhausted budget when reporting is allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) serr_pulse <= 1'b0;
        else        serr_pulse <= exhaust && cfg_serr_en && !cfg_nodeliv_dis;
    end

    // A flag with no set and no clear keeps its value.
    assert_rcv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_tabort && !clr_rcv) |=> $stable(rcv_tabort));

    assert_sig_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_tabort && !clr_sig) |=> $stable(sig_tabort));

    // The error pulse never spans two cycles.
    assert_serr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |=> !serr_pulse);

endmodule

// File: rtl/dly_rd_retry_ctrl.sv
// Delayed read retry controller top: ties the sequencer, termination mapper
// and status block together. Assumes a single delayed read in flight.
module dly_rd_retry_ctrl
    import dlyrd_pkg::*;
#(
    parameter int LEN_W       = 16,
    parameter int RETRY_LIMIT = 1 << 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_prefetch,
    input  logic [LEN_W-1:0] req_len,
    output logic             tgt_issue,
    input  logic             tgt_done,
    input  logic [2:0]       tgt_term,
    input  logic [LEN_W-1:0] tgt_xfer_cnt,
    input  logic             cfg_serr_en,
    input  logic             cfg_nodeliv_dis,
    output logic             rsp_valid,
    output logic [2:0]       rsp_code,
    input  logic             sts_wr_en,
    input  logic [1:0]       sts_wr_data,
    output logic             sts_rcv_tabort,
    output logic             sts_sig_tabort,
    output logic             serr_pulse
);

    logic             pf_q;
    logic [LEN_W-1:0] len_q;
    ini_rsp_e         map_code;
    ini_rsp_e         rsp_code_e;
    logic             fin_tabort;
    logic             exhaust;

    assign rsp_code = rsp_code_e;

    dlyrd_seq #(
        .LEN_W       (LEN_W),
        .RETRY_LIMIT (RETRY_LIMIT)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_prefetch (req_prefetch),
        .req_len      (req_len),
        .tgt_issue    (tgt_issue),
        .tgt_done     (tgt_done),
        .tgt_term     (tgt_term),
        .pf_q         (pf_q),
        .len_q        (len_q),
        .map_code     (map_code),
        .rsp_valid    (rsp_valid),
        .rsp_code     (rsp_code_e),
        .fin_tabort   (fin_tabort),
        .exhaust      (exhaust)
    );

    dlyrd_term_map #(
        .LEN_W (LEN_W)
    ) u_map (
        .term     (tgt_term),
        .prefetch (pf_q),
        .want_len (len_q),
        .got_len  (tgt_xfer_cnt),
        .code     (map_code)
    );

    dlyrd_status u_sts (
        .clk             (clk),
        .rst_n           (rst_n),
        .set_tabort      (fin_tabort),
        .exhaust         (exhaust),
        .cfg_serr_en     (cfg_serr_en),
        .cfg_nodeliv_dis (cfg_nodeliv_dis),
        .wr_en           (sts_wr_en),
        .wr_data         (sts_wr_data),
        .rcv_tabort      (sts_rcv_tabort),
        .sig_tabort      (sts_sig_tabort),
        .serr_pulse      (serr_pulse)
    );

    // A target-abort response comes with both abort flags set.
    assert_tabort_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 3'd2) |-> (sts_rcv_tabort && sts_sig_tabort));

    // The error pulse only appears when the gating bits allowed it.
    assert_serr_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |-> $past(cfg_serr_en && !cfg_nodeliv_dis));

    // The error pulse always comes with the retry-limit response.
    assert_serr_with_giveup_R3: assert property (@(posedge clk) disable iff (!rst_n)
        serr_pulse |-> (rsp_valid && rsp_code == 3'd4));

endmodule

// File: tb/dly_rd_retry_ctrl_test.sv
`timescale 1ns/1ps
module dly_rd_retry_ctrl_test;

    localparam int LW    = 8;
    localparam int LIMIT = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic          req_ready;
    logic          req_prefetch;
    logic [LW-1:0] req_len;
    logic          tgt_issue;
    logic          tgt_done;
    logic [2:0]    tgt_term;
    logic [LW-1:0] tgt_xfer_cnt;
    logic          cfg_serr_en;
    logic          cfg_nodeliv_dis;
    logic          rsp_valid;
    logic [2:0]    rsp_code;
    logic          sts_wr_en;
    logic [1:0]    sts_wr_data;
    logic          sts_rcv_tabort;
    logic          sts_sig_tabort;
    logic          serr_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dly_rd_retry_ctrl #(.LEN_W(LW), .RETRY_LIMIT(LIMIT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_prefetch(req_prefetch), .req_len(req_len), .tgt_issue(tgt_issue),
        .tgt_done(tgt_done), .tgt_term(tgt_term), .tgt_xfer_cnt(tgt_xfer_cnt),
        .cfg_serr_en(cfg_serr_en), .cfg_nodeliv_dis(cfg_nodeliv_dis),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .sts_wr_en(sts_wr_en),
        .sts_wr_data(sts_wr_data), .sts_rcv_tabort(sts_rcv_tabort),
        .sts_sig_tabort(sts_sig_tabort), .serr_pulse(serr_pulse)
    );

    // Vector: {prefetch, req_len, term, xfer, expected code}
    localparam int VW = 1 + LW + 3 + LW + 3;
    localparam int NV = 10;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b1, 8'd8, 3'd0, 8'd8, 3'd0},
        {1'b1, 8'd8, 3'd0, 8'd4, 3'd1},
        {1'b1, 8'd4, 3'd0, 8'd8, 3'd0},
        {1'b0, 8'd1, 3'd0, 8'd1, 3'd1},
        {1'b0, 8'd8, 3'd0, 8'd1, 3'd1},
        {1'b1, 8'd8, 3'd2, 8'd3, 3'd1},
        {1'b0, 8'd3, 3'd2, 8'd3, 3'd0},
        {1'b0, 8'd9, 3'd2, 8'd3, 3'd1},
        {1'b1, 8'd4, 3'd3, 8'd0, 3'd2},
        {1'b0, 8'd4, 3'd4, 8'd0, 3'd3}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic start_req(input logic pf, input logic [LW-1:0] len);
        @(negedge clk);
        req_valid = 1'b1; req_prefetch = pf; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Called in the issue cycle; ends the attempt and returns after the edge.
    task automatic attempt(input logic [2:0] term, input logic [LW-1:0] xfer);
        @(negedge clk);
        tgt_done = 1'b1; tgt_term = term; tgt_xfer_cnt = xfer;
        @(negedge clk);
        tgt_done = 1'b0;
    endtask

    task automatic clear_flags(input logic [1:0] mask);
        @(negedge clk);
        sts_wr_en = 1'b1; sts_wr_data = mask;
        @(negedge clk);
        sts_wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        string tag;
        rst_n = 1'b0; req_valid = 1'b0; req_prefetch = 1'b0; req_len = '0;
        tgt_done = 1'b0; tgt_term = 3'd0; tgt_xfer_cnt = '0;
        cfg_serr_en = 1'b1; cfg_nodeliv_dis = 1'b0;
        sts_wr_en = 1'b0; sts_wr_data = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 ready after reset", req_ready, 1);
        chk("R1 issue after reset", tgt_issue, 0);
        chk("R1 rsp after reset", rsp_valid, 0);
        chk("R1 serr after reset", serr_pulse, 0);
        chk("R1 flags after reset", {sts_sig_tabort, sts_rcv_tabort}, 0);

        // Vector walk: termination mapping R5 R6 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            logic          pf;
            logic [LW-1:0] len, xf;
            logic [2:0]    tm, ex;
            {pf, len, tm, xf, ex} = VEC[i];
            if (tm == 3'd3)      tag = "R5";
            else if (tm == 3'd4) tag = "R6";
            else if (tm == 3'd2) tag = "R9";
            else if (pf)         tag = "R7";
            else                 tag = "R8";
            clear_flags(2'b11);
            start_req(pf, len);
            chk("R1 issue after accept", tgt_issue, 1);
            attempt(tm, xf);
            chk({tag, " rsp_valid"}, rsp_valid, 1);
            chk({tag, " rsp_code"}, rsp_code, ex);
            chk({tag, " flags"}, {sts_sig_tabort, sts_rcv_tabort}, (tm == 3'd3) ? 2'b11 : 2'b00);
            chk({tag, " no reissue"}, tgt_issue, 0);
            chk({tag, " no serr"}, serr_pulse, 0);
        end

        // R1: issue lasts one cycle
        start_req(1'b1, 8'd2);
        chk("R1 issue high", tgt_issue, 1);
        @(negedge clk);
        chk("R1 issue single cycle", tgt_issue, 0);
        tgt_done = 1'b1; tgt_term = 3'd0; tgt_xfer_cnt = 8'd2;
        @(negedge clk);
        tgt_done = 1'b0;
        chk("R1 complete code", rsp_code, 0);

        // R2: retries inside the budget re-issue
        start_req(1'b1, 8'd4);
        for (int k = 0; k < 2; k++) begin
            attempt(3'd1, 8'd0);
            chk("R2 reissue after retry", tgt_issue, 1);
            chk("R2 no response on retry", rsp_valid, 0);
        end
        attempt(3'd0, 8'd4);
        chk("R2 final response", rsp_valid, 1);
        chk("R2 final code", rsp_code, 0);

        // R3 R4: exhaustion with reporting enabled
        cfg_serr_en = 1'b1; cfg_nodeliv_dis = 1'b0;
        start_req(1'b0, 8'd4);
        for (int k = 0; k < LIMIT - 1; k++) begin
            attempt(3'd1, 8'd0);
            chk("R3 reissue below limit", tgt_issue, 1);
        end
        attempt(3'd1, 8'd0);
        chk("R3 limit response", rsp_valid, 1);
        chk("R3 limit code", rsp_code, 4);
        chk("R4 serr raised", serr_pulse, 1);
        chk("R3 no issue after limit", tgt_issue, 0);
        @(negedge clk);
        chk("R4 serr one cycle", serr_pulse, 0);
        chk("R3 idle after limit", req_ready, 1);

        // R3: new request gets a fresh budget
        start_req(1'b1, 8'd4);
        for (int k = 0; k < LIMIT - 1; k++) begin
            attempt(3'd1, 8'd0);
            chk("R3 fresh budget reissue", tgt_issue, 1);
            chk("R3 fresh budget no rsp", rsp_valid, 0);
        end
        attempt(3'd0, 8'd4);
        chk("R3 fresh budget completes", rsp_code, 0);

        // R4: gating by the disable bit and by the enable bit
        cfg_serr_en = 1'b1; cfg_nodeliv_dis = 1'b1;
        start_req(1'b0, 8'd1);
        for (int k = 0; k < LIMIT; k++) attempt(3'd1, 8'd0);
        chk("R4 limit code when disabled", rsp_code, 4);
        chk("R4 no serr when disabled", serr_pulse, 0);
        cfg_serr_en = 1'b0; cfg_nodeliv_dis = 1'b0;
        start_req(1'b0, 8'd1);
        for (int k = 0; k < LIMIT; k++) attempt(3'd1, 8'd0);
        chk("R4 limit code when not enabled", rsp_code, 4);
        chk("R4 no serr when not enabled", serr_pulse, 0);
        cfg_serr_en = 1'b1;

        // R10: write-one-to-clear per bit
        start_req(1'b1, 8'd4);
        attempt(3'd3, 8'd0);
        chk("R10 both flags set", {sts_sig_tabort, sts_rcv_tabort}, 2'b11);
        clear_flags(2'b01);
        chk("R10 clear bit0 only", {sts_sig_tabort, sts_rcv_tabort}, 2'b10);
        clear_flags(2'b00);
        chk("R10 zero mask keeps", {sts_sig_tabort, sts_rcv_tabort}, 2'b10);
        clear_flags(2'b10);
        chk("R10 clear bit1", {sts_sig_tabort, sts_rcv_tabort}, 2'b00);

        // R10: set wins over a clear in the same cycle
        start_req(1'b1, 8'd4);
        @(negedge clk);
        tgt_done = 1'b1; tgt_term = 3'd3; sts_wr_en = 1'b1; sts_wr_data = 2'b11;
        @(negedge clk);
        tgt_done = 1'b0; sts_wr_en = 1'b0;
        chk("R10 set beats clear", {sts_sig_tabort, sts_rcv_tabort}, 2'b11);
        clear_flags(2'b11);

        // R11: request during a read is ignored
        start_req(1'b1, 8'd4);
        @(negedge clk);
        chk("R11 not ready while busy", req_ready, 0);
        req_valid = 1'b1; req_prefetch = 1'b0; req_len = 8'd200;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 no issue from ignored request", tgt_issue, 0);
        tgt_done = 1'b1; tgt_term = 3'd0; tgt_xfer_cnt = 8'd4;
        @(negedge clk);
        tgt_done = 1'b0;
        chk("R11 original fields used", rsp_code, 0);
        @(negedge clk);
        chk("R11 no stray issue", tgt_issue, 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule